// File: doc/BRIEF.md
# Programmable SPI Master with Control/Status Byte

This block is an SPI master placed behind a minimal host register port with two addresses: a control/status byte and an 8-bit data register. Software sets the serial clock rate, the bit order and the interrupt routing in the control byte, then writes a byte to the data register. That write starts a full-duplex 8-bit exchange in SPI mode 0. The block drives the serial clock, the outgoing data line and one active-low select. It samples the incoming data line, and at the end the received byte can be read back from the data register.

The block also watches an active-low interrupt request from the attached device. It passes that request through a two-flop synchronizer and shows it as a read-only status bit. When enabled, it drives exactly one of four host interrupt lines, picked by a two-bit selector. A read-only busy bit reports a transfer in progress. The serial clock half period is a base count, 32 system clocks by default, shifted right by the rate code. With a 66.667 MHz system clock this gives roughly 1.04, 2.08, 4.17 and 8.33 MHz.

Top module: `spi_master_csr`

## Requirements
- R1: Address 0 is the control/status byte: bits 7:6 select the interrupt line, bits 5:4 the rate, bit 3 the interrupt enable, bit 2 the LSB-first order, bit 1 the synchronized device interrupt, bit 0 busy. Reset clears every field, and written fields 7:2 read back unchanged.
- R2: Writes to bits 1:0 of the control byte have no effect; those bits always reflect device interrupt and busy state.
- R3: Rate code c gives an SCLK half period of (BASE_HALF >> c) system clocks, so a transfer keeps the select low for exactly 16*(BASE_HALF >> c) cycles (512, 256, 128, 64 by default).
- R4: With bit 2 at 0, the byte goes out MSB first and the incoming bits fill the received byte from the MSB down.
- R5: With bit 2 at 1, the byte goes out LSB first and the incoming bits fill the received byte from the LSB up.
- R6: SCLK idles low. Select is driven low (active) exactly while busy reads 1, and each transfer gives exactly 8 rising SCLK edges. MISO is sampled on rising edges and MOSI changes on falling edges.
- R7: A write to address 1 while idle starts a transfer; afterwards, address 1 reads the received byte.
- R8: A write to address 1 during a transfer is ignored and does not disturb the bits sent or received.
- R9: Rate or order written during a transfer reads back at once but applies only from the next transfer.
- R10: The device interrupt status bit reads 1 two clock edges after the device interrupt input goes low, and reads 0 two edges after the input is released.
- R11: With the enable set and the request active, selector codes 00, 01, 10, 11 drive host_irq bit 0, 1, 2, 3 respectively (lines 3, 4, 5, 10), and no other bit.
- R12: With the enable at 0, host_irq stays all zero whatever the device interrupt does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 1 | Register select: 0 control/status, 1 data |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for the addressed register |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| ss_n | output | 1 | Active-low device select |
| dev_irq_n | input | 1 | Active-low interrupt request from the device |
| host_irq | output | 4 | Routed interrupt lines (bits map to lines 3, 4, 5, 10) |

## Verification
A wrong edge counter or divider shows up as a select-low window of the wrong length. It is visible as soon as that transfer ends, at most 512 cycles after the start. A wrong shift direction or a bad capture point corrupts both the byte the modelled device receives and the byte read back from the data register in the same transfer. A broken synchronizer or routing decode shows on host_irq and on status bit 1 within two or three clock edges of a change on the device interrupt input. Transfers that carry a mid-flight write expose a busy-gating fault through a changed bit stream, or through a select window whose length matches the wrong rate.

// File: rtl/spi_master_csr.sv
module spi_master_csr #(
  parameter int BASE_HALF = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       ss_n,
  input  logic       dev_irq_n,
  output logic [3:0] host_irq
);
  localparam int CW   = (BASE_HALF > 1) ? $clog2(BASE_HALF) : 1;
  localparam int NB   = 8;
  localparam int BCW  = $clog2(NB + 1);

  logic [1:0]     irq_sel, rate, x_rate;
  logic           irq_en, lsb_first, x_lsb;
  logic           busy, cap, sclk_q;
  logic [CW-1:0]  cnt, half_m1;
  logic [BCW-1:0] nfall;
  logic [NB-1:0]  sh;
  logic [1:0]     sync_q;
  logic           irq_act;

  assign half_m1 = CW'((BASE_HALF >> x_rate) - 1);
  assign irq_act = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], ~dev_irq_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_sel   <= '0;
      rate      <= '0;
      irq_en    <= 1'b0;
      lsb_first <= 1'b0;
      x_rate    <= '0;
      x_lsb     <= 1'b0;
      busy      <= 1'b0;
      cap       <= 1'b0;
      sclk_q    <= 1'b0;
      cnt       <= '0;
      nfall     <= '0;
      sh        <= '0;
    end else begin
      if (wr_en && !addr)
        {irq_sel, rate, irq_en, lsb_first} <= wdata[7:2];
      if (!busy) begin
        if (wr_en && addr) begin
          sh     <= wdata;
          busy   <= 1'b1;
          x_rate <= rate;
          x_lsb  <= lsb_first;
          cnt    <= '0;
          nfall  <= '0;
        end
      end else if (cnt == half_m1) begin
        cnt    <= '0;
        sclk_q <= ~sclk_q;
        if (!sclk_q) begin
          cap <= miso;
        end else begin
          sh    <= x_lsb ? {cap, sh[NB-1:1]} : {sh[NB-2:0], cap};
          nfall <= nfall + 1'b1;
          if (nfall == BCW'(NB - 1)) busy <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sclk     = sclk_q;
  assign ss_n     = ~busy;
  assign mosi     = busy & (x_lsb ? sh[0] : sh[NB-1]);
  assign rdata    = addr ? sh : {irq_sel, rate, irq_en, lsb_first, irq_act, busy};
  assign host_irq = (irq_en && irq_act) ? (4'b0001 << irq_sel) : 4'b0000;
endmodule

// File: rtl/spi_master_csr_chk.sv
module spi_master_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       sclk,
  input logic       ss_n,
  input logic       irq_en,
  input logic [3:0] host_irq
);
  a_r6_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sclk);

  a_r6_clock_moves_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(busy));

  a_r11_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(host_irq));

  a_r12_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> host_irq == 4'b0000);
endmodule

bind spi_master_csr spi_master_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .ss_n(ss_n),
  .irq_en(irq_en), .host_irq(host_irq)
);

// File: tb/spi_master_csr_test.sv
module spi_master_csr_test;
  localparam int CLK_PERIOD = 15;
  localparam int HALF0 = 32;

  logic clk = 0, rst_n = 0, wr_en = 0, addr = 0, dev_irq_n = 1;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic sclk, mosi, miso, ss_n;
  logic [3:0] host_irq;

  spi_master_csr uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .dev_irq_n(dev_irq_n), .host_irq(host_irq));

  always #(CLK_PERIOD/2.0) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // device model
  logic [7:0] s_tx = 0, s_rx = 0;
  logic s_lsb = 0;
  int fall_cnt = 0, rise_cnt = 0, s_base = 0, low_cnt = 0, idx;
  assign idx  = fall_cnt - s_base;
  assign miso = s_lsb ? s_tx[idx[2:0]] : s_tx[3'd7 - idx[2:0]];
  always @(negedge sclk) fall_cnt++;
  always @(posedge sclk) begin
    rise_cnt++;
    s_rx = s_lsb ? {mosi, s_rx[7:1]} : {s_rx[6:0], mosi};
  end
  always @(negedge clk) if (!ss_n) low_cnt++;

  // {rate, lsb, host byte, device byte}
  localparam logic [18:0] VEC [6] = '{
    {2'd0, 1'b0, 8'hA5, 8'h3C},
    {2'd1, 1'b0, 8'h81, 8'hF0},
    {2'd2, 1'b1, 8'h01, 8'h80},
    {2'd3, 1'b1, 8'hC3, 8'h5A},
    {2'd3, 1'b0, 8'hFF, 8'h00},
    {2'd2, 1'b0, 8'h00, 8'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] stx, input logic lsb,
                      input bit mid, input int exp_len, input string tag);
    logic [7:0] d;
    int low0, rise0;
    s_tx = stx; s_lsb = lsb; s_base = fall_cnt;
    low0 = low_cnt; rise0 = rise_cnt;
    wr(1'b1, tx);
    if (mid) begin
      repeat (40) @(negedge clk);
      rd(1'b0, d);
      check("R6 busy bit mid transfer", d[0], 1'b1);
      wr(1'b1, 8'hFF);                              // R8 ignored write
      wr(1'b0, {2'b00, 2'd3, 1'b0, 1'b1, 2'b00});   // R9 new rate/order
      rd(1'b0, d);
      check("R9 control reads back at once", d[7:2], {2'b00, 2'd3, 1'b0, 1'b1});
    end
    while (!ss_n) @(negedge clk);
    check({tag, " select low window"}, low_cnt - low0, exp_len);
    check("R6 eight rising edges", rise_cnt - rise0, 8);
    check({tag, " device received byte"}, s_rx, tx);
    rd(1'b1, d);
    check("R7 received byte readback", d, stx);
    rd(1'b0, d);
    check("R6 busy clear after transfer", d[0], 1'b0);
    check("R6 sclk idle low", sclk, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, d);
    check("R1 reset status", d, 8'h00);
    check("R6 reset sclk", sclk, 1'b0);
    check("R6 reset select", ss_n, 1'b1);
    check("R12 reset host_irq", host_irq, 4'h0);

    // R1 readback, R2 bits 1:0 ignored
    wr(1'b0, 8'hF7);
    rd(1'b0, d);
    check("R1 readback fields", d[7:2], 6'h3D);
    check("R2 low bits ignored", d[1:0], 2'b00);
    wr(1'b0, 8'h00);

    // vector table: R3, R4, R5, R7
    foreach (VEC[i]) begin
      wr(1'b0, {2'b00, VEC[i][18:17], 1'b0, VEC[i][16], 2'b00});
      xfer(VEC[i][15:8], VEC[i][7:0], VEC[i][16], 1'b0,
           16 * (HALF0 >> VEC[i][18:17]), VEC[i][16] ? "R5 R3" : "R4 R3");
    end

    // R8, R9: mid-transfer writes; old rate (512) and MSB-first kept
    wr(1'b0, 8'h00);
    xfer(8'h5A, 8'h96, 1'b0, 1'b1, 512, "R8 R9");
    // next transfer uses rate 3, LSB first
    xfer(8'h12, 8'h34, 1'b1, 1'b0, 64, "R9 next transfer");

    // R10, R12: request with enable off
    wr(1'b0, 8'h00);
    dev_irq_n = 0;
    @(negedge clk);
    rd(1'b0, d);
    check("R10 one edge not yet visible", d[1], 1'b0);
    @(negedge clk);
    rd(1'b0, d);
    check("R10 visible after two edges", d[1], 1'b1);
    check("R12 disabled no output", host_irq, 4'h0);
    // R11 routing
    for (int s = 0; s < 4; s++) begin
      wr(1'b0, {s[1:0], 2'b00, 1'b1, 3'b000});
      check("R11 routed line", host_irq, 4'b0001 << s);
    end
    wr(1'b0, 8'h00);
    check("R12 enable cleared", host_irq, 4'h0);
    wr(1'b0, 8'hC8);
    dev_irq_n = 1;
    @(negedge clk);
    check("R10 release one edge still held", host_irq, 4'b1000);
    @(negedge clk);
    rd(1'b0, d);
    check("R10 status clears on release", d[1], 1'b0);
    check("R11 output drops on release", host_irq, 4'h0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule